// File: doc/BRIEF.md
# Atomic Read-Modify Swap Sequencer

This block runs the bus side of an atomic exchange between a processor register and a memory location. When a start strobe is accepted, the block captures the memory address, the value to store, the transfer size and the current fetch address. It then walks through four fixed cycles: an instruction prefetch, a locked read, a locked write of the stored value to the same address, and an internal cycle. In the internal cycle the word obtained by the read is handed to the register file, unless the read or the write was aborted.

The lock output covers exactly the read and the write, so an external arbiter can keep any other master off the bus between them. The read value is held inside the block until the internal cycle. For byte exchanges, the block takes the byte lane chosen by the low address bits and zero-extends it. It also repeats the stored byte on every lane of the write data. Start requests that arrive while a sequence is under way are dropped.

Top module: `swap_seq`

## Requirements
- R1: While reset is low, and in every idle cycle, the block drives bus_req_o=0, bus_we_o=0, bus_lock_o=0, rf_we_o=0, bus_size_o=2'b10, bus_addr_o=0, bus_wdata_o=0 and rf_wdata_o=0.
- R2: In the cycle after a clock edge that samples start_i high in the idle state (cycle 1), the block drives a read request (bus_req_o=1, bus_we_o=0) of word size (bus_size_o=2'b10) at the captured fetch_pc_i, with bus_lock_o=0.
- R3: In cycle 2 the block drives a read request at the captured mem_addr_i, with bus_lock_o=1. The size code is 2'b00 for a byte exchange (byte_mode_i=1) and 2'b10 for a word exchange. rd_data_i is sampled at the clock edge that ends cycle 2.
- R4: In cycle 3 the block drives a write request (bus_we_o=1) with bus_lock_o=1 to the same address and with the same size code as cycle 2. bus_wdata_o is the captured store value for a word exchange, or its bits [7:0] repeated on all four byte lanes for a byte exchange. bus_wdata_o is 0 in every other cycle.
- R5: In cycle 4 the block makes no memory request (bus_req_o=0). It drives bus_addr_o to the captured fetch address plus 4 and bus_size_o=2'b10, and it asserts rf_we_o=1 with rf_wdata_o equal to the word sampled at the end of cycle 2. rf_wdata_o is 0 whenever rf_we_o is 0.
- R6: For a byte exchange, the committed value is byte lane k of the sampled read word (bits 8k+7..8k) zero-extended to 32 bits, where k is bits [1:0] of the captured address.
- R7: bus_lock_o is 1 in cycles 2 and 3 and 0 in every other cycle.
- R8: abort_i high in cycle 2 or cycle 3 keeps rf_we_o at 0 in cycle 4. abort_i in cycle 1, cycle 4 or the idle state has no effect.
- R9: start_i is ignored in cycles 1 to 4, including cycle 4. The following sequence starts only from a start_i sampled in the idle state, and it uses the operands present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Request to begin an exchange (sampled in idle) |
| mem_addr_i | input | 32 | Memory address taken from the address register |
| store_data_i | input | 32 | Register value to be written to memory |
| byte_mode_i | input | 1 | 1 = byte exchange, 0 = word exchange |
| fetch_pc_i | input | 32 | Address of the current instruction prefetch |
| abort_i | input | 1 | Memory abort for the current bus cycle |
| rd_data_i | input | 32 | Read data returned by memory |
| bus_addr_o | output | 32 | Bus address |
| bus_we_o | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_size_o | output | 2 | Transfer size code (2'b00 byte, 2'b10 word) |
| bus_lock_o | output | 1 | Bus lock across the read and write |
| bus_req_o | output | 1 | Memory request for this cycle |
| bus_wdata_o | output | 32 | Write data |
| rf_we_o | output | 1 | Destination register write enable |
| rf_wdata_o | output | 32 | Destination register write value |

## Verification
Counting from the edge that accepts start_i, the prefetch outputs appear one cycle later and the locked read two cycles later. The locked write follows three cycles later and the register commit four cycles later. The read word must come from the edge that ends the read cycle, and an abort must be sampled at the edges that end cycles 2 and 3. The bench keeps a behavioural model that advances on the same edges as the design. It drives inputs one nanosecond after each rising edge and compares every output on the falling edge, so each expected value is checked in the cycle it is due. Sequences include back-to-back starts, a start held high, aborts in each of the four cycles, read data changed outside the read cycle, and byte exchanges on every lane.

// File: rtl/swap_pkg.sv
`timescale 1ns/1ps
package swap_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_FETCH  = 3'd1,
    PH_READ   = 3'd2,
    PH_WRITE  = 3'd3,
    PH_COMMIT = 3'd4
  } swap_phase_e;

  localparam logic [1:0] SIZE_BYTE = 2'b00;
  localparam logic [1:0] SIZE_WORD = 2'b10;

endpackage

// File: rtl/swap_phase_ctrl.sv
`timescale 1ns/1ps
module swap_phase_ctrl
  import swap_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  output swap_phase_e phase_o,
  output logic        accept_o
);

  swap_phase_e phase_q;
  swap_phase_e phase_d;

  // next-state process
  always_comb begin
    phase_d  = phase_q;
    accept_o = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (start_i) begin
          phase_d  = PH_FETCH;
          accept_o = 1'b1;
        end
      end
      PH_FETCH:  phase_d = PH_READ;
      PH_READ:   phase_d = PH_WRITE;
      PH_WRITE:  phase_d = PH_COMMIT;
      PH_COMMIT: phase_d = PH_IDLE;
      default:   phase_d = PH_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
    end else begin
      phase_q <= phase_d;
    end
  end

  assign phase_o = phase_q;

endmodule

// File: rtl/swap_capture.sv
`timescale 1ns/1ps
module swap_capture
  import swap_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  swap_phase_e       phase_i,
  input  logic              accept_i,
  input  logic [ADDR_W-1:0] mem_addr_i,
  input  logic [DATA_W-1:0] store_data_i,
  input  logic              byte_mode_i,
  input  logic [ADDR_W-1:0] fetch_pc_i,
  input  logic              abort_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] store_o,
  output logic              byte_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] held_o,
  output logic              aborted_o
);

  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] store_q;
  logic              byte_q;
  logic [ADDR_W-1:0] pc_q;
  logic [DATA_W-1:0] held_q, held_d;
  logic              aborted_q, aborted_d;
  logic              held_en, abort_en;
  logic [LANE_W-1:0] lane_sel;
  logic [7:0]        lane_byte;

  assign lane_sel = addr_q[LANE_W-1:0];

  // byte lane pick from the read word
  always_comb begin
    lane_byte = rd_data_i[7:0];
    for (int k = 0; k < LANES; k++) begin
      if (lane_sel == LANE_W'(k)) begin
        lane_byte = rd_data_i[8*k +: 8];
      end
    end
  end

  always_comb begin
    held_en = (phase_i == PH_READ);
    if (byte_q) begin
      held_d = {{(DATA_W-8){1'b0}}, lane_byte};
    end else begin
      held_d = rd_data_i;
    end
  end

  always_comb begin
    abort_en  = accept_i
              | (((phase_i == PH_READ) | (phase_i == PH_WRITE)) & abort_i);
    aborted_d = accept_i ? 1'b0 : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      store_q <= '0;
      byte_q  <= 1'b0;
      pc_q    <= '0;
    end else if (accept_i) begin
      addr_q  <= mem_addr_i;
      store_q <= store_data_i;
      byte_q  <= byte_mode_i;
      pc_q    <= fetch_pc_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= '0;
    end else if (held_en) begin
      held_q <= held_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aborted_q <= 1'b0;
    end else if (abort_en) begin
      aborted_q <= aborted_d;
    end
  end

  assign addr_o    = addr_q;
  assign store_o   = store_q;
  assign byte_o    = byte_q;
  assign pc_o      = pc_q;
  assign held_o    = held_q;
  assign aborted_o = aborted_q;

endmodule

// File: rtl/swap_bus_drive.sv
`timescale 1ns/1ps
module swap_bus_drive
  import swap_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int INSTR_BYTES = 4
) (
  input  swap_phase_e       phase_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] store_i,
  input  logic              byte_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DATA_W-1:0] held_i,
  input  logic              aborted_i,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              bus_we_o,
  output logic [1:0]        bus_size_o,
  output logic              bus_lock_o,
  output logic              bus_req_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic              rf_we_o,
  output logic [DATA_W-1:0] rf_wdata_o
);

  localparam int LANES = DATA_W / 8;

  logic [1:0]        data_size;
  logic [DATA_W-1:0] store_bus;

  assign data_size = byte_i ? SIZE_BYTE : SIZE_WORD;
  assign store_bus = byte_i ? {LANES{store_i[7:0]}} : store_i;

  always_comb begin
    bus_addr_o  = '0;
    bus_we_o    = 1'b0;
    bus_size_o  = SIZE_WORD;
    bus_lock_o  = 1'b0;
    bus_req_o   = 1'b0;
    bus_wdata_o = '0;
    rf_we_o     = 1'b0;
    rf_wdata_o  = '0;
    unique case (phase_i)
      PH_FETCH: begin
        bus_addr_o = pc_i;
        bus_req_o  = 1'b1;
      end
      PH_READ: begin
        bus_addr_o = addr_i;
        bus_req_o  = 1'b1;
        bus_lock_o = 1'b1;
        bus_size_o = data_size;
      end
      PH_WRITE: begin
        bus_addr_o  = addr_i;
        bus_req_o   = 1'b1;
        bus_lock_o  = 1'b1;
        bus_we_o    = 1'b1;
        bus_size_o  = data_size;
        bus_wdata_o = store_bus;
      end
      PH_COMMIT: begin
        bus_addr_o = pc_i + ADDR_W'(INSTR_BYTES);
        rf_we_o    = ~aborted_i;
        rf_wdata_o = aborted_i ? '0 : held_i;
      end
      default: begin
      end
    endcase
  end

endmodule

// File: rtl/swap_seq.sv
`timescale 1ns/1ps
module swap_seq
  import swap_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int INSTR_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] mem_addr_i,
  input  logic [DATA_W-1:0] store_data_i,
  input  logic              byte_mode_i,
  input  logic [ADDR_W-1:0] fetch_pc_i,
  input  logic              abort_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              bus_we_o,
  output logic [1:0]        bus_size_o,
  output logic              bus_lock_o,
  output logic              bus_req_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic              rf_we_o,
  output logic [DATA_W-1:0] rf_wdata_o
);

  swap_phase_e       phase;
  logic              accept;
  logic [ADDR_W-1:0] cap_addr;
  logic [DATA_W-1:0] cap_store;
  logic              cap_byte;
  logic [ADDR_W-1:0] cap_pc;
  logic [DATA_W-1:0] cap_held;
  logic              cap_aborted;

  swap_phase_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .phase_o  (phase),
    .accept_o (accept)
  );

  swap_capture #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_capture (
    .clk          (clk),
    .rst_n        (rst_n),
    .phase_i      (phase),
    .accept_i     (accept),
    .mem_addr_i   (mem_addr_i),
    .store_data_i (store_data_i),
    .byte_mode_i  (byte_mode_i),
    .fetch_pc_i   (fetch_pc_i),
    .abort_i      (abort_i),
    .rd_data_i    (rd_data_i),
    .addr_o       (cap_addr),
    .store_o      (cap_store),
    .byte_o       (cap_byte),
    .pc_o         (cap_pc),
    .held_o       (cap_held),
    .aborted_o    (cap_aborted)
  );

  swap_bus_drive #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .INSTR_BYTES (INSTR_BYTES)
  ) u_drive (
    .phase_i     (phase),
    .addr_i      (cap_addr),
    .store_i     (cap_store),
    .byte_i      (cap_byte),
    .pc_i        (cap_pc),
    .held_i      (cap_held),
    .aborted_i   (cap_aborted),
    .bus_addr_o  (bus_addr_o),
    .bus_we_o    (bus_we_o),
    .bus_size_o  (bus_size_o),
    .bus_lock_o  (bus_lock_o),
    .bus_req_o   (bus_req_o),
    .bus_wdata_o (bus_wdata_o),
    .rf_we_o     (rf_we_o),
    .rf_wdata_o  (rf_wdata_o)
  );

endmodule

// File: rtl/swap_seq_chk.sv
`timescale 1ns/1ps
module swap_seq_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              abort_i,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic              bus_we_o,
  input logic [1:0]        bus_size_o,
  input logic              bus_lock_o,
  input logic              bus_req_o,
  input logic              rf_we_o
);

  assert_lock_needs_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_lock_o |-> bus_req_o);

  assert_lock_opens_on_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_lock_o) |-> !bus_we_o);

  assert_lock_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_lock_o) |=> (bus_lock_o && bus_we_o));

  assert_lock_two_cycles_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_lock_o && $past(bus_lock_o)) |=> !bus_lock_o);

  assert_same_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_lock_o && $past(bus_lock_o)) |-> $stable(bus_addr_o));

  assert_write_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we_o |-> bus_lock_o);

  assert_commit_internal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we_o |-> (!bus_req_o && !bus_lock_o && $past(bus_we_o)));

  assert_abort_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we_o |-> (!$past(abort_i) && !$past(abort_i, 2)));

  assert_size_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_o |-> (bus_size_o == 2'b00 || bus_size_o == 2'b10));

endmodule

bind swap_seq swap_seq_chk #(.ADDR_W(ADDR_W)) u_swap_seq_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .abort_i    (abort_i),
  .bus_addr_o (bus_addr_o),
  .bus_we_o   (bus_we_o),
  .bus_size_o (bus_size_o),
  .bus_lock_o (bus_lock_o),
  .bus_req_o  (bus_req_o),
  .rf_we_o    (rf_we_o)
);

// File: tb/swap_seq_tb_top.sv
`timescale 1ns/1ps
module swap_seq_tb_top;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [31:0] mem_addr_i;
  logic [31:0] store_data_i;
  logic        byte_mode_i;
  logic [31:0] fetch_pc_i;
  logic        abort_i;
  logic [31:0] rd_data_i;
  logic [31:0] bus_addr_o;
  logic        bus_we_o;
  logic [1:0]  bus_size_o;
  logic        bus_lock_o;
  logic        bus_req_o;
  logic [31:0] bus_wdata_o;
  logic        rf_we_o;
  logic [31:0] rf_wdata_o;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  swap_seq dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .mem_addr_i   (mem_addr_i),
    .store_data_i (store_data_i),
    .byte_mode_i  (byte_mode_i),
    .fetch_pc_i   (fetch_pc_i),
    .abort_i      (abort_i),
    .rd_data_i    (rd_data_i),
    .bus_addr_o   (bus_addr_o),
    .bus_we_o     (bus_we_o),
    .bus_size_o   (bus_size_o),
    .bus_lock_o   (bus_lock_o),
    .bus_req_o    (bus_req_o),
    .bus_wdata_o  (bus_wdata_o),
    .rf_we_o      (rf_we_o),
    .rf_wdata_o   (rf_wdata_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // ---------------- behavioural reference ----------------
  int          m_step;     // 0 idle, 1..4 sequence cycles
  logic [31:0] m_pc, m_addr, m_store, m_read;
  bit          m_byte, m_abort;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_step  = 0;
      m_abort = 0;
      m_read  = 0;
    end else begin
      if (m_step == 0) begin
        if (start_i) begin
          m_step  = 1;
          m_pc    = fetch_pc_i;
          m_addr  = mem_addr_i;
          m_store = store_data_i;
          m_byte  = byte_mode_i;
          m_abort = 0;
        end
      end else if (m_step == 1) begin
        m_step = 2;
      end else if (m_step == 2) begin
        if (abort_i) m_abort = 1;
        if (m_byte) m_read = (rd_data_i >> (m_addr[1:0] * 8)) & 32'hFF;
        else        m_read = rd_data_i;
        m_step = 3;
      end else if (m_step == 3) begin
        if (abort_i) m_abort = 1;
        m_step = 4;
      end else begin
        m_step = 0;
      end
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      logic [1:0] sz;
      sz = m_byte ? 2'b00 : 2'b10;
      case (m_step)
        0: begin
          chk("R1", "req", 32'(bus_req_o), 0);
          chk("R1", "we", 32'(bus_we_o), 0);
          chk("R1", "lock", 32'(bus_lock_o), 0);
          chk("R1", "rf_we", 32'(rf_we_o), 0);
          chk("R1", "size", 32'(bus_size_o), 2);
          chk("R1", "addr", bus_addr_o, 0);
          chk("R1", "rf_wdata", rf_wdata_o, 0);
          chk("R4", "wdata idle", bus_wdata_o, 0);
        end
        1: begin
          chk("R2", "req", 32'(bus_req_o), 1);
          chk("R2", "we", 32'(bus_we_o), 0);
          chk("R7", "lock c1", 32'(bus_lock_o), 0);
          chk("R2", "size", 32'(bus_size_o), 2);
          chk("R2/R9", "addr", bus_addr_o, m_pc);
          chk("R2", "rf_we", 32'(rf_we_o), 0);
          chk("R4", "wdata c1", bus_wdata_o, 0);
        end
        2: begin
          chk("R3", "req", 32'(bus_req_o), 1);
          chk("R3", "we", 32'(bus_we_o), 0);
          chk("R7", "lock c2", 32'(bus_lock_o), 1);
          chk("R3", "size", 32'(bus_size_o), 32'(sz));
          chk("R3", "addr", bus_addr_o, m_addr);
          chk("R3", "rf_we", 32'(rf_we_o), 0);
          chk("R4", "wdata c2", bus_wdata_o, 0);
        end
        3: begin
          chk("R4", "req", 32'(bus_req_o), 1);
          chk("R4", "we", 32'(bus_we_o), 1);
          chk("R7", "lock c3", 32'(bus_lock_o), 1);
          chk("R4", "size", 32'(bus_size_o), 32'(sz));
          chk("R4", "addr", bus_addr_o, m_addr);
          chk("R4", "wdata", bus_wdata_o,
              m_byte ? {4{m_store[7:0]}} : m_store);
          chk("R4", "rf_we", 32'(rf_we_o), 0);
        end
        default: begin
          chk("R5", "req", 32'(bus_req_o), 0);
          chk("R5", "we", 32'(bus_we_o), 0);
          chk("R7", "lock c4", 32'(bus_lock_o), 0);
          chk("R5", "size", 32'(bus_size_o), 2);
          chk("R5", "addr", bus_addr_o, m_pc + 32'd4);
          chk("R8", "rf_we", 32'(rf_we_o), m_abort ? 0 : 1);
          chk(m_byte ? "R6" : "R5", "rf_wdata", rf_wdata_o, m_abort ? 0 : m_read);
          chk("R4", "wdata c4", bus_wdata_o, 0);
        end
      endcase
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // abort_at: cycle number (1..4) in which abort_i is raised, 0 for none
  task automatic swap_op(input logic [31:0] a, input logic [31:0] s,
                         input logic [31:0] pc, input bit b, input int abort_at,
                         input logic [31:0] rd);
    start_i = 1; mem_addr_i = a; store_data_i = s; fetch_pc_i = pc;
    byte_mode_i = b; abort_i = 0;
    tick();                                   // now in cycle 1
    start_i = 1; mem_addr_i = ~a;             // R9: ignored while busy
    abort_i = (abort_at == 1); rd_data_i = 32'hDEAD0001;
    tick();                                   // cycle 2
    abort_i = (abort_at == 2); rd_data_i = rd;
    tick();                                   // cycle 3
    abort_i = (abort_at == 3); rd_data_i = ~rd;
    tick();                                   // cycle 4
    abort_i = (abort_at == 4); start_i = 1;   // R9: start in cycle 4 ignored
    rd_data_i = 32'h0BAD0BAD;
    tick();                                   // idle
    start_i = 0; abort_i = 0;
    tick();
  endtask

  initial begin
    rst_n = 0; start_i = 0; mem_addr_i = 0; store_data_i = 0;
    byte_mode_i = 0; fetch_pc_i = 0; abort_i = 0; rd_data_i = 0;
    repeat (3) tick();
    start_i = 1;                              // R1: start under reset has no effect
    tick();
    start_i = 0;
    rst_n = 1;
    tick();
    // word exchange, no abort
    swap_op(32'h0000_1000, 32'hCAFE_F00D, 32'h0000_0200, 0, 0, 32'h1234_5678);
    // byte exchanges, every lane (R6)
    for (int k = 0; k < 4; k++)
      swap_op(32'h0000_2000 + k, 32'h0000_00A5 + k, 32'h0000_0300, 1, 0, 32'h8899_AABB);
    // aborts in each cycle (R8)
    for (int c = 1; c <= 4; c++)
      swap_op(32'h0000_3004, 32'h5555_AAAA, 32'h0000_0400, 0, c, 32'h7777_1111);
    swap_op(32'h0000_3005, 32'h0000_00F0, 32'h0000_0500, 1, 2, 32'hFFFF_FFFF);
    // start held high: back-to-back sequences separated by one idle cycle (R9)
    start_i = 1; mem_addr_i = 32'h40; store_data_i = 32'h99; fetch_pc_i = 32'h600;
    repeat (12) begin
      rd_data_i = $urandom;
      tick();
    end
    start_i = 0;
    // random traffic
    repeat (600) begin
      start_i = ($urandom % 3) == 0;
      abort_i = ($urandom % 5) == 0;
      byte_mode_i = $urandom;
      mem_addr_i = $urandom;
      store_data_i = $urandom;
      fetch_pc_i = $urandom;
      rd_data_i = $urandom;
      tick();
    end
    start_i = 0; abort_i = 0;
    repeat (6) tick();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog R1..: run did not complete, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule